// File: doc/BRIEF.md
# SDRAM Command Timing Enforcer

This block sits between whatever decides which SDRAM command comes next and the memory command bus. A requester offers one command at a time over a valid/ready handshake. The block accepts it only when every inter-command delay that applies to it has run out. It then puts the command on its output for exactly one cycle. While the command waits, a stall vector shows which delays are still holding it back. A command that makes no sense in the current device state is consumed at once, flagged and never issued.

The delays are loaded through a small register write port, one field per write. Every field is 4 bits wide and holds the required number of memory clock cycles minus one, so each delay covers 1 to 16 cycles. The block watches two consistency rules that tie the write-recovery setting to the other fields and raises a configuration error while either rule is broken. Writes to the fields are taken only while no command is being offered.

Top module: `sdram_cmd_timer`

## Requirements
- R1: Command codes are 0 mode-register load, 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh, 6 self-refresh entry, 7 self-refresh exit. An accepted legal command appears on `iss_valid`/`iss_cmd` for one cycle, in the cycle after the handshake. A field value N gives a gap of N+1 cycles between the triggering issue and the gated issue, and a value of 0 allows back-to-back issue.
- R2: After a mode-register load, an activate or an auto refresh waits the mode-register delay (field select 0).
- R3: After a self-refresh exit, an activate waits the exit delay (field select 1).
- R4: After a self-refresh entry, a self-refresh exit waits the minimum self-refresh period (field select 2).
- R5: After an auto refresh, both an activate and a further auto refresh wait the row-cycle delay (field select 3).
- R6: After a write, a precharge waits the write-recovery delay (field select 4).
- R7: After a precharge, every command waits the row-precharge delay (field select 5).
- R8: After an activate, a read or a write waits the row-to-column delay (field select 6).
- R9: `stall_why` bit k is high exactly while a legal command is offered and the delay for field select k applies to it and has not run out. Bit 0 is mode-register, 1 exit, 2 minimum self-refresh, 3 row-cycle, 4 write-recovery, 5 row-precharge and 6 row-to-column. Any set bit blocks acceptance.
- R10: A read or write while no row is open, a self-refresh exit outside self-refresh, or any other command inside self-refresh is accepted at once without waiting. It pulses `illegal_o` in the next cycle and is not issued. Activate opens the row and precharge closes it.
- R11: `cfg_err` is high while write-recovery cycles < (minimum self-refresh cycles − row-to-column cycles) or write-recovery cycles < (row-cycle cycles − row-to-column cycles − row-precharge cycles), where each cycle count is its field value plus one.
- R12: A field write (`cfg_we`, `cfg_sel` 0 to 6) takes effect at the clock edge only when `cmd_valid` is low. Otherwise it is ignored.
- R13: Reset clears every field and delay, closes the row, leaves self-refresh and drives `iss_valid`, `illegal_o`, `stall_why` and `cfg_err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Field write strobe |
| cfg_sel | input | 3 | Field select, 0 to 6 |
| cfg_data | input | 4 | Field value, cycles minus one |
| cmd_valid | input | 1 | Command offered |
| cmd_type | input | 3 | Offered command code |
| cmd_ready | output | 1 | Command accepted this cycle |
| iss_valid | output | 1 | Command issued to memory |
| iss_cmd | output | 3 | Issued command code |
| illegal_o | output | 1 | Last accepted command was rejected |
| stall_why | output | 7 | Delays blocking the offered command |
| cfg_err | output | 1 | Recovery setting breaks a consistency rule |

## Verification
The bench offers each command the moment the previous one is accepted. Each measured wait therefore equals the remaining count of the delay that binds. An off-by-one in the minus-one encoding would shift every wait by one cycle, and a delay tied to the wrong command would give a zero wait where a nonzero one belongs. It offers illegal commands and expects them to be consumed in a single cycle. A design that made them wait out delays, or issued them, would show a nonzero wait or an `iss_valid`. It drives `cfg_err` to the exact boundary of the recovery rule and writes a field while a command is offered. An inclusive/exclusive slip, or a write that is not blocked, would then show on `cfg_err`.

// File: rtl/sdram_cmd_timer.sv
module sdram_cmd_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [TW-1:0] cfg_data,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_type,
  output logic          cmd_ready,
  output logic          iss_valid,
  output logic [2:0]    iss_cmd,
  output logic          illegal_o,
  output logic [6:0]    stall_why,
  output logic          cfg_err
);

  localparam int NC = 7;
  localparam int K_MRD = 0, K_XSR = 1, K_SRM = 2, K_RC = 3, K_WR = 4, K_RP = 5, K_RCD = 6;
  localparam logic [2:0] C_MRS = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_SRE = 3'd6, C_SRX = 3'd7;

  logic [TW-1:0]    fld [NC];
  logic [TW-1:0]    cnt [NC];
  logic [NC*TW-1:0] fld_flat;
  logic [NC-1:0]    busy, need, trig;
  logic             row_open, in_sr, bad, go;
  int               c_wr, c_srm, c_rc, c_rcd, c_rp;

  always_comb begin
    need = '0;
    trig = '0;
    need[K_RP] = 1'b1;
    case (cmd_type)
      C_MRS: trig[K_MRD] = 1'b1;
      C_ACT: begin
        need[K_MRD] = 1'b1; need[K_XSR] = 1'b1; need[K_RC] = 1'b1;
        trig[K_RCD] = 1'b1;
      end
      C_RD:  need[K_RCD] = 1'b1;
      C_WR:  begin need[K_RCD] = 1'b1; trig[K_WR] = 1'b1; end
      C_PRE: begin need[K_WR] = 1'b1; trig[K_RP] = 1'b1; end
      C_REF: begin need[K_MRD] = 1'b1; need[K_RC] = 1'b1; trig[K_RC] = 1'b1; end
      C_SRE: trig[K_SRM] = 1'b1;
      C_SRX: begin need[K_SRM] = 1'b1; trig[K_XSR] = 1'b1; end
      default: ;
    endcase
  end

  assign bad = (((cmd_type == C_RD) || (cmd_type == C_WR)) && !row_open)
             || ((cmd_type == C_SRX) && !in_sr)
             || ((cmd_type != C_SRX) && in_sr);

  assign stall_why = {NC{cmd_valid && !bad}} & need & busy;
  assign cmd_ready = cmd_valid && (bad || ((need & busy) == '0));
  assign go        = cmd_valid && cmd_ready && !bad;

  for (genvar i = 0; i < NC; i++) begin : g_delay
    assign busy[i] = |cnt[i];
    assign fld_flat[i*TW +: TW] = fld[i];

    always_ff @(posedge clk) begin
      if (!rst_n)
        fld[i] <= '0;
      else if (cfg_we && !cmd_valid && (cfg_sel == 3'(i)))
        fld[i] <= cfg_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[i] <= '0;
      else if (go && trig[i])
        cnt[i] <= fld[i];
      else if (busy[i])
        cnt[i] <= cnt[i] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid <= 1'b0;
      iss_cmd   <= C_MRS;
      illegal_o <= 1'b0;
      row_open  <= 1'b0;
      in_sr     <= 1'b0;
    end else begin
      iss_valid <= go;
      if (go) iss_cmd <= cmd_type;
      illegal_o <= cmd_valid && bad;
      if (go && cmd_type == C_ACT) row_open <= 1'b1;
      if (go && cmd_type == C_PRE) row_open <= 1'b0;
      if (go && cmd_type == C_SRE) in_sr <= 1'b1;
      if (go && cmd_type == C_SRX) in_sr <= 1'b0;
    end
  end

  always_comb begin
    c_wr  = int'(fld[K_WR])  + 1;
    c_srm = int'(fld[K_SRM]) + 1;
    c_rc  = int'(fld[K_RC])  + 1;
    c_rcd = int'(fld[K_RCD]) + 1;
    c_rp  = int'(fld[K_RP])  + 1;
  end

  assign cfg_err = (c_wr < (c_srm - c_rcd)) || (c_wr < (c_rc - c_rcd - c_rp));

  assert_no_issue_and_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid && illegal_o));

  assert_column_needs_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (iss_cmd == C_RD || iss_cmd == C_WR)) |-> $past(row_open));

  assert_sr_min_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cmd == C_SRE && $past(fld[K_SRM]) != '0) |-> !(go && cmd_type == C_SRX));

  assert_ref_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cmd == C_REF && $past(fld[K_RC]) != '0)
      |-> !(go && (cmd_type == C_REF || cmd_type == C_ACT)));

  assert_pre_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cmd == C_PRE && $past(fld[K_RP]) != '0) |-> !go);

  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cmd_valid) |=> $stable(fld_flat));

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_why != '0) |-> !cmd_ready);

endmodule

// File: tb/test_sdram_cmd_timer.sv
`timescale 1ns/1ps
module test_sdram_cmd_timer;

  typedef struct packed {
    logic [2:0] c;
    logic [3:0] w;
    logic       ill;
    logic [6:0] st;
  } vec_t;

  // MRS0 ACT1 RD2 WR3 PRE4 REF5 SRE6 SRX7; stall bits: 0 mrd 1 xsr 2 srmin 3 rc 4 wr 5 rp 6 rcd
  localparam vec_t TBL [12] = '{
    '{3'd0, 4'd0, 1'b0, 7'h00},
    '{3'd1, 4'd2, 1'b0, 7'h01},
    '{3'd2, 4'd2, 1'b0, 7'h40},
    '{3'd3, 4'd0, 1'b0, 7'h00},
    '{3'd4, 4'd3, 1'b0, 7'h10},
    '{3'd5, 4'd1, 1'b0, 7'h20},
    '{3'd5, 4'd6, 1'b0, 7'h08},
    '{3'd1, 4'd6, 1'b0, 7'h08},
    '{3'd4, 4'd0, 1'b0, 7'h00},
    '{3'd6, 4'd1, 1'b0, 7'h20},
    '{3'd7, 4'd5, 1'b0, 7'h04},
    '{3'd1, 4'd4, 1'b0, 7'h02}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [3:0] cfg_data = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_type = '0;
  logic cmd_ready, iss_valid, illegal_o, cfg_err;
  logic [2:0] iss_cmd;
  logic [6:0] stall_why;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_cmd_timer i_sdram_cmd_timer (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_data, .cmd_valid, .cmd_type,
    .cmd_ready, .iss_valid, .iss_cmd, .illegal_o, .stall_why, .cfg_err);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string wait_tag(input logic [6:0] st);
    case (st)
      7'h01: return "R2 wait";
      7'h02: return "R3 wait";
      7'h04: return "R4 wait";
      7'h08: return "R5 wait";
      7'h10: return "R6 wait";
      7'h20: return "R7 wait";
      7'h40: return "R8 wait";
      default: return "R1 wait";
    endcase
  endfunction

  // Called at a negedge; returns at the negedge after the handshake.
  task automatic send(input logic [2:0] c, input int ew, input bit eill,
                      input logic [6:0] est, input bit poke);
    int w = 0;
    cmd_valid = 1'b1;
    cmd_type  = c;
    if (poke) begin cfg_we = 1'b1; cfg_sel = 3'd4; cfg_data = 4'd0; end
    #1;
    chk("R9 stall vector", int'(stall_why), int'(est));
    while (!cmd_ready && w < 40) begin
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      #1;
      w++;
    end
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    cfg_we = 1'b0;
    if (eill) begin
      chk("R10 wait", w, ew);
      chk("R10 illegal pulse", int'(illegal_o), 1);
      chk("R10 not issued", int'(iss_valid), 0);
    end else begin
      chk(wait_tag(est), w, ew);
      chk("R1 issue", int'({iss_valid, iss_cmd, illegal_o}), int'({1'b1, c, 1'b0}));
    end
  endtask

  task automatic wcfg(input logic [2:0] s, input logic [3:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 iss_valid", int'(iss_valid), 0);
    chk("R13 illegal", int'(illegal_o), 0);
    chk("R13 stall", int'(stall_why), 0);
    chk("R13 cfg_err", int'(cfg_err), 0);
    chk("R13 ready idle", int'(cmd_ready), 0);

    wcfg(3'd0, 4'd2); wcfg(3'd1, 4'd4); wcfg(3'd2, 4'd5); wcfg(3'd3, 4'd6);
    wcfg(3'd4, 4'd3); wcfg(3'd5, 4'd1); wcfg(3'd6, 4'd2);
    chk("R11 consistent config", int'(cfg_err), 0);

    for (int i = 0; i < 12; i++)
      send(TBL[i].c, int'(TBL[i].w), TBL[i].ill, TBL[i].st, 1'b0);

    // R10 illegal commands
    send(3'd4, 0, 1'b0, 7'h00, 1'b0);
    send(3'd2, 0, 1'b1, 7'h00, 1'b0);
    send(3'd7, 0, 1'b1, 7'h00, 1'b0);
    send(3'd6, 0, 1'b0, 7'h00, 1'b0);
    send(3'd1, 0, 1'b1, 7'h00, 1'b0);
    send(3'd7, 4, 1'b0, 7'h04, 1'b0);   // R4 after one consumed illegal cycle

    // R12 write attempt while a command is offered
    send(3'd1, 4, 1'b0, 7'h02, 1'b1);
    chk("R12 write ignored", int'(cfg_err), 0);

    // R11 rule boundaries
    wcfg(3'd4, 4'd0); chk("R11 recovery too short", int'(cfg_err), 1);
    wcfg(3'd4, 4'd2); chk("R11 exact boundary", int'(cfg_err), 0);
    wcfg(3'd4, 4'd1); chk("R11 one below boundary", int'(cfg_err), 1);
    wcfg(3'd4, 4'd3);
    wcfg(3'd3, 4'd15); chk("R11 row-cycle rule", int'(cfg_err), 1);
    wcfg(3'd3, 4'd6); chk("R11 restored", int'(cfg_err), 0);

    // R1 zero field gives back-to-back issue
    wcfg(3'd5, 4'd0);
    send(3'd4, 0, 1'b0, 7'h00, 1'b0);
    send(3'd4, 0, 1'b0, 7'h00, 1'b0);
    send(3'd5, 0, 1'b0, 7'h00, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule